// File: doc/BRIEF.md
# Top-of-hour chime sequencer

This block drives the enable line of a buzzer so that the clock beeps just before each new hour. It reads the minute and second digits of a time-of-day counter, each digit in 8421 BCD. It finds the last ten seconds of the hour from those digits alone and sets the enable high in every other second of that stretch. The result is five one-second beeps, and each beep is followed by a one-second pause.

The window is the final ten seconds, 59:50 through 59:59. Inside it the minute tens digit reads 5, the minute units digit reads 9 and the second tens digit reads 5. The second units digit then selects sound or silence. The enable comes from a flop, so it moves only on a clock edge and cannot glitch while the digit bus settles. It always reflects the digits present on the previous edge. When the time is set by hand into or out of the window, the enable follows on the next edge. The block does not generate the tone and does not keep the time.

Top module: `hour_chime`

## Requirements
- R1: While `rst_n` is low, and on the first sample after reset, `buzz_en` is 0.
- R2: `buzz_en` is registered. A change on the digit inputs shows at `buzz_en` only after the next rising edge of `clk`, and not before it.
- R3: `buzz_en` is 0 whenever the minute tens digit is not 5, the minute units digit is not 9, or the second tens digit is not 5.
- R4: At 59:50, 59:52, 59:54, 59:56 and 59:58 (second units digit 0, 2, 4, 6 or 8), `buzz_en` is 1.
- R5: At 59:51, 59:53, 59:55, 59:57 and 59:59 (second units digit odd), `buzz_en` is 0.
- R6: At 00:00 of the new hour `buzz_en` is 0.
- R7: A second units digit that is not valid BCD (10 to 15) gives `buzz_en` = 0, even when its value is even.
- R8: When the digits jump into or out of the window in one step, as in a manual correction, `buzz_en` takes the new value on the next clock edge.
- R9: Stepping the time one second at a time from 59:49 to 00:00 produces exactly five rising edges on `buzz_en`. Each beep lasts one second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock on which the time digits update |
| rst_n | input | 1 | Asynchronous active-low reset |
| min_tens | input | 4 | Minute tens digit, BCD |
| min_units | input | 4 | Minute units digit, BCD |
| sec_tens | input | 4 | Second tens digit, BCD |
| sec_units | input | 4 | Second units digit, BCD |
| buzz_en | output | 1 | Buzzer enable, registered |

## Verification
The hardest cases to reach are the jumps a manual time correction makes. One is a step straight into the middle of the window. The other is a step out of the window while a beep is sounding. The second exposes a design that holds the beep instead of re-reading the digits. The stimulus places the digits at arbitrary times such as 12:34 → 59:52 → 07:15. It checks the enable just before and just after the edge that follows each jump. The invalid codes 10, 12 and 14 on the second units digit are also applied inside 59:5x, because these even values would sound if the decode tested parity alone.

// File: rtl/hour_chime.sv
module hour_chime #(
  parameter int DW        = 4,
  parameter int WIN_MT    = 5,
  parameter int WIN_MU    = 9,
  parameter int WIN_ST    = 5,
  parameter int LAST_BEEP = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] min_tens,
  input  logic [DW-1:0] min_units,
  input  logic [DW-1:0] sec_tens,
  input  logic [DW-1:0] sec_units,
  output logic          buzz_en
);

  localparam logic [DW-1:0] MT_K = DW'(WIN_MT);
  localparam logic [DW-1:0] MU_K = DW'(WIN_MU);
  localparam logic [DW-1:0] ST_K = DW'(WIN_ST);
  localparam logic [DW-1:0] LB_K = DW'(LAST_BEEP);

  logic in_window;
  logic beep_slot;

  assign in_window = (min_tens == MT_K) && (min_units == MU_K) && (sec_tens == ST_K);
  assign beep_slot = !sec_units[0] && (sec_units <= LB_K);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) buzz_en <= 1'b0;
    else        buzz_en <= in_window && beep_slot;

  // R3
  window_digits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    buzz_en |-> ($past(min_tens) == MT_K && $past(min_units) == MU_K && $past(sec_tens) == ST_K));

  // R4
  even_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    buzz_en |-> (!$past(sec_units[0]) && $past(sec_units) <= LB_K));

  // R5
  odd_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(sec_units[0])) |-> !buzz_en);

  // R6
  new_hour_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(min_tens) == '0 && $past(min_units) == '0) |-> !buzz_en);

  // R7
  bad_bcd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(sec_units) > DW'(9)) |-> !buzz_en);

endmodule

// File: tb/hour_chime_test.sv
module hour_chime_test;
  logic clk = 0;
  logic rst_n = 0;
  logic [3:0] mt = 0, mu = 0, st = 0, su = 0;
  logic buzz;
  int total = 0, bad = 0;
  int cycles = 0;
  bit done = 0;

  always #4 clk = ~clk;

  hour_chime uut (.clk(clk), .rst_n(rst_n), .min_tens(mt), .min_units(mu),
                  .sec_tens(st), .sec_units(su), .buzz_en(buzz));

  task automatic check(input logic exp, input string req);
    total++;
    if (buzz !== exp) begin
      bad++;
      $display("FAIL %s time=%0d%0d:%0d%0d buzz=%b expected=%b", req, mt, mu, st, su, buzz, exp);
    end
  endtask

  task automatic put(input int a, input int b, input int c, input int d);
    @(negedge clk);
    mt = 4'(a); mu = 4'(b); st = 4'(c); su = 4'(d);
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 0;
    put(5, 9, 5, 0);
    settle();
    check(1'b0, "R1");
    rst_n = 1;
    put(1, 1, 1, 1);
    settle();
    check(1'b0, "R1");
  endtask

  task automatic t_even_odd();
    for (int s = 0; s < 10; s++) begin
      put(5, 9, 5, s);
      settle();
      if (s % 2 == 0) check(1'b1, "R4");
      else            check(1'b0, "R5");
    end
  endtask

  task automatic t_outside();
    put(5, 8, 5, 0); settle(); check(1'b0, "R3");
    put(4, 9, 5, 2); settle(); check(1'b0, "R3");
    put(5, 9, 4, 4); settle(); check(1'b0, "R3");
    put(0, 9, 5, 6); settle(); check(1'b0, "R3");
    put(0, 0, 0, 0); settle(); check(1'b0, "R6");
  endtask

  task automatic t_invalid();
    for (int s = 10; s < 16; s++) begin
      put(5, 9, 5, s);
      settle();
      check(1'b0, "R7");
    end
  endtask

  task automatic t_latency();
    put(1, 2, 3, 4); settle();
    put(5, 9, 5, 6);
    #1 check(1'b0, "R2");
    settle(); check(1'b1, "R2");
    put(5, 9, 5, 7);
    #1 check(1'b1, "R2");
    settle(); check(1'b0, "R2");
  endtask

  task automatic t_correct();
    put(1, 2, 3, 4); settle(); check(1'b0, "R8");
    put(5, 9, 5, 2); settle(); check(1'b1, "R8");
    put(0, 7, 1, 5); settle(); check(1'b0, "R8");
    put(5, 9, 5, 8); settle(); check(1'b1, "R8");
  endtask

  task automatic t_sweep();
    int rises = 0, on_len = 0;
    logic prev;
    put(5, 9, 4, 9); settle();
    prev = buzz;
    for (int s = 0; s < 11; s++) begin
      if (s < 10) put(5, 9, 5, s); else put(0, 0, 0, 0);
      settle();
      if (buzz && !prev) rises++;
      if (buzz) on_len++;
      if (buzz && prev) begin
        total++; bad++;
        $display("FAIL R9 beep longer than one second at s=%0d buzz=1 expected=0", s);
      end
      prev = buzz;
    end
    total++;
    if (rises != 5) begin bad++; $display("FAIL R9 rises=%0d expected=5", rises); end
    total++;
    if (on_len != 5) begin bad++; $display("FAIL R9 on seconds=%0d expected=5", on_len); end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog expired buzz=%b expected=finish", buzz);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_even_odd();
    t_outside();
    t_invalid();
    t_latency();
    t_correct();
    t_sweep();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule